// File: doc/BRIEF.md
# Dual-Rate Pixel Dimming PWM

This block produces the on/off drive for the red, green and blue emitters of a single pixel. Each colour has its own duty value, and one shared global brightness value dims all three colours together. A fast PWM stage turns each colour value into a duty cycle. A much slower PWM stage gates all three outputs on and off according to the brightness value, so the light that reaches the eye is the product of the two duty cycles.

Both stages are timed from one system-clock prescaler. The colour counter steps once per prescaler tick, and the brightness slot counter steps once per full colour period. The brightness period is therefore exactly `2**BRIGHT_W` colour periods. With the default widths this is 32 colour periods, close to the factor of about 33 between a roughly 19.2 kHz colour rate and a roughly 580 Hz brightness rate. New colour values are taken only when a colour period starts, and a new brightness only when a brightness period starts, so a duty change never cuts a pulse short.

Top module: `rgb_dim_pwm`

## Requirements
- R1: After reset, and until the first colour period ends (`DIV * 2**COLOR_W` clocks after reset release), all three drive outputs are 0.
- R2: Within a colour period the colour count runs from 0 to `2**COLOR_W - 1`. A colour stage is on at count c exactly when c is below its applied value, so a value of 0 never turns its output on.
- R3: The full-scale colour value (all ones) keeps its colour stage on for every count except the last one of the period.
- R4: drive_o bit 0 is red, bit 1 is green and bit 2 is blue. Each bit is 1 exactly when its colour stage is on and the brightness gate is on. For a brightness b below full scale, the gate is on during the colour periods whose slot index (0 to `2**BRIGHT_W - 1` within the brightness period) is below b.
- R5: Full-scale brightness (all ones) keeps the gate on in every slot. Brightness 0 keeps all outputs off.
- R6: A colour input value is applied at the first colour-period boundary after it is presented. Until then the previously applied value governs that output.
- R7: A brightness input value is applied only at the first brightness-period boundary (every `2**BRIGHT_W` colour periods) after it is presented. Until then the previously applied value governs.
- R8: The colour count advances once every DIV clocks. At full-scale brightness, an output with applied value v is on for exactly `v * DIV` clocks of each colour period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| red_i | input | COLOR_W | Red duty value |
| grn_i | input | COLOR_W | Green duty value |
| blu_i | input | COLOR_W | Blue duty value |
| bright_i | input | BRIGHT_W | Global brightness value |
| drive_o | output | 3 | Emitter enables: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds the block with COLOR_W = 4, BRIGHT_W = 3 and DIV = 2. A colour period is then 32 clocks and a brightness period is 256 clocks. At this size every one of the 8 brightness codes can be combined with every one of the 16 colour codes, each held for a full brightness period, and every output can be compared clock by clock against arithmetic in the bench. Inputs change at times that do not line up with period boundaries, so the deferred application of both colour and brightness values is exercised on every change.

// File: rtl/rgb_dim_pwm.sv
module rgb_dim_pwm #(
  parameter int COLOR_W  = 8,
  parameter int BRIGHT_W = 5,
  parameter int DIV      = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COLOR_W-1:0]  red_i,
  input  logic [COLOR_W-1:0]  grn_i,
  input  logic [COLOR_W-1:0]  blu_i,
  input  logic [BRIGHT_W-1:0] bright_i,
  output logic [2:0]          drive_o
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0]       PRE_LAST = PW'(DIV - 1);
  localparam logic [COLOR_W-1:0]  CNT_LAST = '1;
  localparam logic [BRIGHT_W-1:0] BRI_FULL = '1;

  logic [PW-1:0]             pre;
  logic [COLOR_W-1:0]        cnt;
  logic [BRIGHT_W-1:0]       slot;
  logic [BRIGHT_W-1:0]       bri_q;
  logic [2:0][COLOR_W-1:0]   col_q;
  logic                      tick, col_end, bri_end, gate;

  assign tick    = (pre == PRE_LAST);
  assign col_end = tick && (cnt == CNT_LAST);
  assign bri_end = col_end && (slot == BRI_FULL);
  assign gate    = (bri_q == BRI_FULL) || (slot < bri_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt   <= '0;
      slot  <= '0;
      bri_q <= '0;
      col_q <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
      if (col_end) begin
        slot  <= slot + 1'b1;
        col_q <= {blu_i, grn_i, red_i};
      end
      if (bri_end) bri_q <= bright_i;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_ch
    assign drive_o[i] = gate && (cnt < col_q[i]);
  end

endmodule

// File: rtl/rgb_dim_pwm_chk.sv
module rgb_dim_pwm_chk #(
  parameter int COLOR_W  = 8,
  parameter int BRIGHT_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               drive_o,
  input logic                     tick,
  input logic [COLOR_W-1:0]       cnt,
  input logic [BRIGHT_W-1:0]      slot,
  input logic [BRIGHT_W-1:0]      bri_q,
  input logic [2:0][COLOR_W-1:0]  col_q
);

  for (genvar i = 0; i < 3; i++) begin : g_ch
    // R2
    zero_color_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_q[i] == '0) |-> !drive_o[i]);
  end

  // R5
  zero_bright_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bri_q == '0) |-> (drive_o == 3'b000));

  // R6
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(col_q));

  // R7
  bright_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) || (slot != '0)) |-> $stable(bri_q));

  // R8
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1));

endmodule

bind rgb_dim_pwm rgb_dim_pwm_chk #(.COLOR_W(COLOR_W), .BRIGHT_W(BRIGHT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .drive_o(drive_o),
  .tick   (tick),
  .cnt    (cnt),
  .slot   (slot),
  .bri_q  (bri_q),
  .col_q  (col_q)
);

// File: tb/test_rgb_dim_pwm.sv
module test_rgb_dim_pwm;
  localparam int CW  = 4;
  localparam int BW  = 3;
  localparam int DIV = 2;
  localparam int NC  = 1 << CW;
  localparam int NB  = 1 << BW;
  localparam int CP  = DIV * NC;
  localparam int BP  = CP * NB;
  localparam int CMAX = NC - 1;
  localparam int BMAX = NB - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] red = '0, grn = '0, blu = '0;
  logic [BW-1:0] bright = '0;
  logic [2:0]    drive;

  int tests = 0, fails = 0;
  int k = 0;
  int app_c [3] = '{0, 0, 0};
  int app_b = 0;
  int acc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rgb_dim_pwm #(.COLOR_W(CW), .BRIGHT_W(BW), .DIV(DIV)) i_rgb_dim_pwm (
    .clk(clk), .rst_n(rst_n), .red_i(red), .grn_i(grn), .blu_i(blu),
    .bright_i(bright), .drive_o(drive)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  function automatic int in_col(input int ch);
    case (ch)
      0: return int'(red);
      1: return int'(grn);
      default: return int'(blu);
    endcase
  endfunction

  task automatic step();
    int cnt, slot;
    bit gate, exp;
    string tag;
    @(negedge clk);
    k++;
    if (k % CP == 0) begin
      // R8: on-time over the finished colour period at full brightness
      if (app_b == BMAX) chk(acc == app_c[0] * DIV, "R8", acc, app_c[0] * DIV);
      for (int ch = 0; ch < 3; ch++) app_c[ch] = in_col(ch);
      if (k % BP == 0) app_b = int'(bright);
      acc = 0;
    end
    cnt  = (k / DIV) % NC;
    slot = (k / CP) % NB;
    gate = (app_b == BMAX) || (slot < app_b);
    for (int ch = 0; ch < 3; ch++) begin
      exp = gate && (cnt < app_c[ch]);
      if (k < CP) tag = "R1";
      else if (int'(bright) != app_b) tag = "R7";
      else if (in_col(ch) != app_c[ch]) tag = "R6";
      else if (app_b == 0 || app_b == BMAX) tag = "R5";
      else if (app_c[ch] == 0) tag = "R2";
      else if (app_c[ch] == CMAX) tag = "R3";
      else tag = "R4";
      chk(drive[ch] == exp, tag, int'(drive[ch]), int'(exp));
    end
    acc += int'(drive[0]);
  endtask

  initial begin
    red = 4'd9; grn = 4'd15; blu = 4'd0; bright = 3'd7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(drive == 3'b000, "R1", int'(drive), 0);
    end
    rst_n = 1'b1;
    chk(drive == 3'b000, "R1", int'(drive), 0);
    for (int i = 0; i < BP + 77; i++) step();
    for (int b = 0; b < NB; b++) begin
      for (int v = 0; v < NC; v++) begin
        red    = CW'(v);
        grn    = CW'((v * 5 + 3) % NC);
        blu    = CW'(CMAX - v);
        bright = BW'(b);
        for (int i = 0; i < BP; i++) step();
      end
    end
    red = '1; grn = '0; blu = 4'd6; bright = '1;
    for (int i = 0; i < 2 * BP; i++) step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule